// File: doc/BRIEF.md
# Pulse-Coded Token-Bus Frame Transmitter

This block turns one token-bus frame into line symbols and drives them onto a pulse-coded medium. The requester picks a frame kind: invitation, free-buffer enquiry, acknowledge, negative acknowledge or data. For a data frame it also supplies the source ID, the destination ID and the payload length. Payload bytes come from an external byte buffer through an address output with a same-cycle read return. The block adds the alert preamble, the per-character framing and, for data frames, a 16-bit CRC.

Line timing comes from an external quarter-interval enable. Four enables make one unit interval (UI). Each UI carries one line symbol. A symbol is shaped either as a split pulse pair for a transformer-coupled medium or as a single full-width pulse for a backplane medium. A transmit-enable output frames the whole transmission. Its polarity is chosen once, while reset is held.

Top module: `dipulse_tx`

## Requirements
- R1: After reset, while no frame is in progress, `pulse1_n` is 1, `done` is 0, `txen_out` is at its inactive level, and in normal mode `pulse2_n` is 1.
- R2: A frame starts on the first UI boundary after `start` is accepted. It opens with 6 consecutive mark UIs, and `txen_out` turns active at that same boundary.
- R3: Every character occupies 11 UIs: two marks, one space, then the 8 data bits, least significant bit first, with a 1 sent as a mark.
- R4: `kind`=0 (invitation) sends bytes 04h, DID, DID. `kind`=1 (enquiry) sends 85h, DID, DID.
- R5: `kind`=2 (acknowledge) sends the single byte 86h. `kind`=3 (negative acknowledge) sends the single byte 15h.
- R6: `kind`=4 (data) with `pay_len` N in 1..255 sends 01h, SID, DID, DID, (256−N) mod 256, then payload bytes 0..N−1 read at `rd_addr` 0..N−1, then two CRC bytes.
- R7: A data frame with N in 257..508 sends 00h and then (512−N) mod 256 in place of the single count byte. Payload and CRC follow as in R6.
- R8: The CRC uses x^16+x^15+x^2+1 in its bit-reflected form, starts from 0, processes each byte LSB first, and covers every byte from SID through the last payload byte, count bytes included. Its low byte is sent first.
- R9: With `bp_mode`=0, a mark drives `pulse1_n` low in quarters 0–1 of the UI and `pulse2_n` low in quarters 2–3. The two are never low together, and a space leaves both high.
- R10: With `bp_mode`=1, a mark drives `pulse1_n` low for all four quarters. `pulse2_n` is 0 in quarters 0 and 2 and 1 in quarters 1 and 3, which gives a clock at twice the bit rate.
- R11: `txen_out` is active high only if `bp_mode` and `txen_hi_sel` are both 1 while reset is held. In every other case it is active low.
- R12: `done` is high for one clock when the last UI of the frame ends. `txen_out` stays active for one further UI and goes inactive at the next UI boundary, after which a new `start` is accepted.
- R13: A `start` received while a frame is pending, running or in its tail UI is ignored. The running frame is unchanged and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the enable polarity is sampled while it is low |
| qtr_tick | input | 1 | Quarter-UI enable, one clock wide |
| bp_mode | input | 1 | 1 selects backplane pulse shaping |
| txen_hi_sel | input | 1 | Requests an active-high enable (backplane only, sampled in reset) |
| start | input | 1 | Frame request, accepted only when idle |
| kind | input | 3 | Frame kind: 0 invite, 1 enquiry, 2 ack, 3 nak, 4 data |
| src_id | input | 8 | Source ID for data frames |
| dst_id | input | 8 | Destination ID |
| pay_len | input | LEN_W | Payload byte count N for data frames |
| rd_addr | output | LEN_W | Payload byte address |
| rd_data | input | 8 | Payload byte at `rd_addr`, same cycle |
| pulse1_n | output | 1 | First pulse line, active low |
| pulse2_n | output | 1 | Second pulse line, or the double-rate clock in backplane mode |
| txen_out | output | 1 | Line-driver enable |
| done | output | 1 | One-clock end-of-frame pulse |

## Verification
The assertions assume that `qtr_tick` is a single-clock pulse and that `rd_data` is a pure function of `rd_addr` within the same cycle. They also assume that `bp_mode` and `txen_hi_sel` change only while reset is held, and that `kind`, `pay_len` and the IDs are valid whenever `start` is high. The stimulus drives the quarter enable on every other clock from a single process. It changes the mode inputs only inside a reset window. It serves payload from a combinational function of the address. It issues `start` only with legal lengths, 1..255 or 257..508, except for the deliberate extra requests that test R13.

// File: rtl/dptx_pkg.sv
package dptx_pkg;

    typedef enum logic [2:0] {
        FK_INVITE  = 3'd0,
        FK_ENQUIRY = 3'd1,
        FK_ACK     = 3'd2,
        FK_NAK     = 3'd3,
        FK_DATA    = 3'd4
    } frame_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ARM,
        SQ_SEND,
        SQ_TAIL
    } seq_state_e;

    localparam logic [7:0]  CH_INVITE = 8'h04;
    localparam logic [7:0]  CH_ENQ    = 8'h85;
    localparam logic [7:0]  CH_ACK    = 8'h86;
    localparam logic [7:0]  CH_NAK    = 8'h15;
    localparam logic [7:0]  CH_SOH    = 8'h01;

    // x^16 + x^15 + x^2 + 1, bit-reversed for LSB-first processing
    localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

endpackage

// File: rtl/dptx_crc16.sv
module dptx_crc16
    import dptx_pkg::*;
#(
    parameter logic [15:0] POLY = CRC_POLY_REFL
) (
    input  logic [15:0] crc_in,
    input  logic [7:0]  data_in,
    output logic [15:0] crc_out
);
    always_comb begin
        logic [15:0] acc;
        logic        fb;
        acc = crc_in;
        for (int i = 0; i < 8; i++) begin
            fb  = acc[0] ^ data_in[i];
            acc = acc >> 1;
            if (fb) acc = acc ^ POLY;
        end
        crc_out = acc;
    end
endmodule

// File: rtl/dptx_line.sv
module dptx_line (
    input  logic clk,
    input  logic rst_n,
    input  logic qtr_tick,
    input  logic bp_mode,
    input  logic txen_hi_sel,
    input  logic line_bit,
    input  logic line_on,
    output logic ui_adv,
    output logic pulse1_n,
    output logic pulse2_n,
    output logic txen_out
);
    typedef struct packed {
        logic [1:0] qtr;
        logic       pol;
    } line_regs_t;

    line_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (qtr_tick) r_d.qtr = r_q.qtr + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.qtr <= 2'd0;
            r_q.pol <= txen_hi_sel & bp_mode;
        end else begin
            r_q <= r_d;
        end
    end

    assign ui_adv   = qtr_tick && (r_q.qtr == 2'd3);
    assign pulse1_n = ~(line_bit & (bp_mode | ~r_q.qtr[1]));
    assign pulse2_n = bp_mode ? r_q.qtr[0] : ~(line_bit & r_q.qtr[1]);
    assign txen_out = r_q.pol ? line_on : ~line_on;

    // R9: split pulses never overlap on the coupled medium
    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bp_mode |-> (pulse1_n || pulse2_n));

    // R11: a pulse only appears while the enable is at its active level
    p_pulse_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse1_n |-> (txen_out == r_q.pol));

    // R11: polarity may be high only when backplane was chosen in reset
    p_pol_bp_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pol |-> bp_mode);
endmodule

// File: rtl/dptx_seq.sv
module dptx_seq
    import dptx_pkg::*;
#(
    parameter int LEN_W    = 9,
    parameter int ALERT_UI = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ui_adv,
    input  logic             start,
    input  logic [2:0]       kind_in,
    input  logic [7:0]       sid_in,
    input  logic [7:0]       did_in,
    input  logic [LEN_W-1:0] len_in,
    input  logic [7:0]       rd_data,
    output logic [LEN_W-1:0] rd_addr,
    output logic             line_bit,
    output logic             line_on,
    output logic             done
);
    localparam int IDX_W     = LEN_W + 1;
    localparam int SLOT_MAX  = 11;
    localparam int CNT_MAX   = (ALERT_UI > SLOT_MAX) ? ALERT_UI : SLOT_MAX;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);
    localparam int SLOT_SP   = 2;
    localparam int SLOT_LAST = SLOT_MAX - 1;

    typedef struct packed {
        seq_state_e       st;
        logic             in_alert;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [7:0]       sh;
        logic [15:0]      crc;
        logic             bit_o;
        logic             done;
        frame_kind_e      kind;
        logic [7:0]       sid;
        logic [7:0]       did;
        logic [LEN_W-1:0] len;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             is_long;
    logic [IDX_W-1:0] hdr, pay_end, total, nidx;
    logic             last, crc_en, load;
    logic [7:0]       count_byte, byte_val;
    logic [15:0]      crc_nxt;
    logic [CNT_W-1:0] boff;

    assign is_long    = (r_q.len > LEN_W'(255));
    assign hdr        = (r_q.kind == FK_DATA) ? (is_long ? IDX_W'(6) : IDX_W'(5)) : IDX_W'(0);
    assign pay_end    = hdr + IDX_W'(r_q.len);
    assign nidx       = r_q.in_alert ? IDX_W'(0) : r_q.idx + IDX_W'(1);
    assign count_byte = 8'd0 - r_q.len[7:0];
    assign rd_addr    = LEN_W'(nidx - hdr);
    assign crc_en     = (r_q.kind == FK_DATA) && (nidx != IDX_W'(0)) && (nidx < pay_end);
    assign boff       = r_q.cnt - CNT_W'(SLOT_SP);

    always_comb begin
        case (r_q.kind)
            FK_INVITE, FK_ENQUIRY: total = IDX_W'(3);
            FK_DATA:               total = pay_end + IDX_W'(2);
            default:               total = IDX_W'(1);
        endcase
    end
    assign last = (r_q.idx == total - IDX_W'(1));

    always_comb begin
        byte_val = 8'h00;
        case (r_q.kind)
            FK_INVITE:  byte_val = (nidx == IDX_W'(0)) ? CH_INVITE : r_q.did;
            FK_ENQUIRY: byte_val = (nidx == IDX_W'(0)) ? CH_ENQ : r_q.did;
            FK_ACK:     byte_val = CH_ACK;
            FK_NAK:     byte_val = CH_NAK;
            FK_DATA: begin
                if (nidx == IDX_W'(0))                 byte_val = CH_SOH;
                else if (nidx == IDX_W'(1))            byte_val = r_q.sid;
                else if (nidx < IDX_W'(4))             byte_val = r_q.did;
                else if (nidx == IDX_W'(4))            byte_val = is_long ? 8'h00 : count_byte;
                else if (nidx < hdr)                   byte_val = count_byte;
                else if (nidx < pay_end)               byte_val = rd_data;
                else if (nidx == pay_end)              byte_val = r_q.crc[7:0];
                else                                   byte_val = r_q.crc[15:8];
            end
            default:    byte_val = CH_ACK;
        endcase
    end

    dptx_crc16 u_crc (
        .crc_in  (r_q.crc),
        .data_in (byte_val),
        .crc_out (crc_nxt)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        load     = 1'b0;
        case (r_q.st)
            SQ_IDLE: if (start) begin
                r_d.st   = SQ_ARM;
                r_d.kind = frame_kind_e'(kind_in);
                r_d.sid  = sid_in;
                r_d.did  = did_in;
                r_d.len  = len_in;
            end
            SQ_ARM: if (ui_adv) begin
                r_d.st       = SQ_SEND;
                r_d.in_alert = 1'b1;
                r_d.cnt      = '0;
                r_d.idx      = '0;
                r_d.crc      = 16'h0000;
                r_d.bit_o    = 1'b1;
            end
            SQ_SEND: if (ui_adv) begin
                if (r_q.in_alert) begin
                    if (r_q.cnt == CNT_W'(ALERT_UI - 1)) load = 1'b1;
                    else begin
                        r_d.cnt   = r_q.cnt + CNT_W'(1);
                        r_d.bit_o = 1'b1;
                    end
                end else if (r_q.cnt == CNT_W'(SLOT_LAST)) begin
                    if (last) begin
                        r_d.st    = SQ_TAIL;
                        r_d.bit_o = 1'b0;
                        r_d.done  = 1'b1;
                    end else load = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                    if (r_q.cnt < CNT_W'(SLOT_SP - 1))   r_d.bit_o = 1'b1;
                    else if (r_q.cnt == CNT_W'(SLOT_SP - 1)) r_d.bit_o = 1'b0;
                    else r_d.bit_o = r_q.sh[boff[2:0]];
                end
            end
            SQ_TAIL: if (ui_adv) r_d.st = SQ_IDLE;
            default: r_d.st = SQ_IDLE;
        endcase
        if (load) begin
            r_d.in_alert = 1'b0;
            r_d.cnt      = '0;
            r_d.idx      = nidx;
            r_d.sh       = byte_val;
            r_d.bit_o    = 1'b1;
            if (crc_en) r_d.crc = crc_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= SQ_IDLE;
            r_q.kind     <= FK_INVITE;
        end else begin
            r_q <= r_d;
        end
    end

    assign line_bit = r_q.bit_o;
    assign line_on  = (r_q.st == SQ_SEND) || (r_q.st == SQ_TAIL);
    assign done     = r_q.done;

    // R2: every preamble interval is a mark
    p_alert_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SQ_SEND && r_q.in_alert) |-> r_q.bit_o);

    // R3: the third slot of a character is a space
    p_slot_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SQ_SEND && !r_q.in_alert && r_q.cnt == CNT_W'(SLOT_SP)) |-> !r_q.bit_o);

    // R12: completion is a single-clock pulse followed by the tail interval
    p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_tail_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (r_q.st == SQ_TAIL));

    // R13: a request while busy leaves the latched frame untouched
    p_busy_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != SQ_IDLE && start) |=> ($stable(r_q.kind) && $stable(r_q.len) && $stable(r_q.did)));
endmodule

// File: rtl/dipulse_tx.sv
module dipulse_tx
    import dptx_pkg::*;
#(
    parameter int LEN_W    = 9,
    parameter int ALERT_UI = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qtr_tick,
    input  logic             bp_mode,
    input  logic             txen_hi_sel,
    input  logic             start,
    input  logic [2:0]       kind,
    input  logic [7:0]       src_id,
    input  logic [7:0]       dst_id,
    input  logic [LEN_W-1:0] pay_len,
    output logic [LEN_W-1:0] rd_addr,
    input  logic [7:0]       rd_data,
    output logic             pulse1_n,
    output logic             pulse2_n,
    output logic             txen_out,
    output logic             done
);
    logic ui_adv, line_bit, line_on;

    dptx_seq #(
        .LEN_W    (LEN_W),
        .ALERT_UI (ALERT_UI)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ui_adv   (ui_adv),
        .start    (start),
        .kind_in  (kind),
        .sid_in   (src_id),
        .did_in   (dst_id),
        .len_in   (pay_len),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .line_bit (line_bit),
        .line_on  (line_on),
        .done     (done)
    );

    dptx_line u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .qtr_tick    (qtr_tick),
        .bp_mode     (bp_mode),
        .txen_hi_sel (txen_hi_sel),
        .line_bit    (line_bit),
        .line_on     (line_on),
        .ui_adv      (ui_adv),
        .pulse1_n    (pulse1_n),
        .pulse2_n    (pulse2_n),
        .txen_out    (txen_out)
    );
endmodule

// File: tb/dipulse_tx_tb.sv
`timescale 1ns/1ps
module dipulse_tx_tb;
    localparam int LEN_W = 9;

    logic             clk = 1'b0, rst_n = 1'b0, qtr_tick = 1'b0;
    logic             bp_mode = 1'b0, txen_hi_sel = 1'b0, start = 1'b0;
    logic [2:0]       kind = 3'd0;
    logic [7:0]       src_id = 8'd0, dst_id = 8'd0, seed = 8'd0;
    logic [LEN_W-1:0] pay_len = '0;
    logic [LEN_W-1:0] rd_addr;
    logic [7:0]       rd_data;
    logic             pulse1_n, pulse2_n, txen_out, done;

    int    n_chk = 0, n_fail = 0;
    int    exp_q[$];
    bit    mon_en = 0, mon_active = 0, exp_pol = 0, fr_err = 0;
    int    qi = 0, cur = 0, ui_num = 0, mon_frames = 0;
    string fr_tag = "";

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pay_byte(int i);
        return 8'((i * 37 + int'(seed)) % 256);
    endfunction

    assign rd_data = pay_byte(int'(rd_addr));

    dipulse_tx #(.LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .qtr_tick(qtr_tick), .bp_mode(bp_mode),
        .txen_hi_sel(txen_hi_sel), .start(start), .kind(kind), .src_id(src_id),
        .dst_id(dst_id), .pay_len(pay_len), .rd_addr(rd_addr), .rd_data(rd_data),
        .pulse1_n(pulse1_n), .pulse2_n(pulse2_n), .txen_out(txen_out), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic mon_err(input string what, input int act, input int exp);
        if (!fr_err)
            $display("FAIL %s: %s at ui %0d q %0d got %0d expected %0d", fr_tag, what, ui_num, qi, act, exp);
        fr_err = 1;
    endtask

    function automatic logic [15:0] crc_of(input logic [7:0] b[$]);
        logic [15:0] c = 16'h0000;
        foreach (b[k]) begin
            c = c ^ {8'h00, b[k]};
            for (int j = 0; j < 8; j++)
                c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
        end
        return c;
    endfunction

    task automatic finish_frame();
        mon_active = 0;
        n_chk++;
        if (fr_err) n_fail++;
        exp_q.delete();
        mon_frames++;
    endtask

    task automatic new_ui(input bit txa);
        ui_num++;
        if (exp_q.size() == 0) begin
            if (txa) mon_err("enable not released (R12)", 1, 0);
            finish_frame();
        end else if (!txa) begin
            mon_err("enable dropped early (R12)", 0, 1);
            finish_frame();
        end else begin
            cur = exp_q.pop_front();
        end
    endtask

    task automatic sample_quarter();
        bit txa, b, e1, e2, ed;
        txa = (txen_out == exp_pol);
        if (!mon_active) begin
            if (!txa) return;
            mon_active = 1; qi = 0; ui_num = 0;
            new_ui(txa);
        end else begin
            qi = (qi + 1) % 4;
            if (qi == 0) new_ui(txa);
            else if (!txa) mon_err("enable mid-UI (R12)", 0, 1);
        end
        if (!mon_active) return;
        b = (cur == 1);
        if (bp_mode) begin
            e1 = !b; e2 = qi[0];
        end else begin
            e1 = (qi < 2) ? !b : 1'b1;
            e2 = (qi >= 2) ? !b : 1'b1;
        end
        ed = (cur == 2) && (qi == 0);
        if (pulse1_n !== e1) mon_err("pulse1_n", pulse1_n, e1);
        if (pulse2_n !== e2) mon_err("pulse2_n", pulse2_n, e2);
        if (done !== ed)     mon_err("done (R12)", done, ed);
    endtask

    // quarter enable and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (qtr_tick && mon_en) sample_quarter();
            qtr_tick = ~qtr_tick;
        end
    end

    task automatic push_byte(input logic [7:0] v);
        exp_q.push_back(1); exp_q.push_back(1); exp_q.push_back(0);
        for (int i = 0; i < 8; i++) exp_q.push_back(int'(v[i]));
    endtask

    task automatic run_frame(input int k, input logic [7:0] s, input logic [7:0] d,
                             input int n, input string tag, input bit poke);
        logic [7:0] bl[$];
        logic [7:0] cov[$];
        logic [15:0] c;
        int f0;
        case (k)
            0: bl = '{8'h04, d, d};
            1: bl = '{8'h85, d, d};
            2: bl = '{8'h86};
            3: bl = '{8'h15};
            default: begin
                bl = '{8'h01, s, d, d};
                if (n > 255) begin
                    bl.push_back(8'h00);
                    bl.push_back(8'((512 - n) % 256));
                end else bl.push_back(8'((256 - n) % 256));
                for (int i = 0; i < n; i++) bl.push_back(pay_byte(i));
                cov = bl[1:$];
                c = crc_of(cov);
                bl.push_back(c[7:0]);
                bl.push_back(c[15:8]);
            end
        endcase
        exp_q.delete();
        for (int i = 0; i < 6; i++) exp_q.push_back(1);
        foreach (bl[i]) push_byte(bl[i]);
        exp_q.push_back(2);
        fr_tag = tag; fr_err = 0; f0 = mon_frames;
        @(negedge clk);
        start = 1; kind = 3'(k); src_id = s; dst_id = d; pay_len = LEN_W'(n);
        @(negedge clk);
        start = 0;
        if (poke) begin
            start = 1; kind = 3'd2; dst_id = ~d; pay_len = 9'd7;
            @(negedge clk);
            start = 0;
            repeat (300) @(negedge clk);
            start = 1; kind = 3'd3;
            @(negedge clk);
            start = 0;
        end
        while (mon_frames == f0) @(negedge clk);
    endtask

    task automatic do_reset(input bit bp, input bit sel);
        mon_en = 0; mon_active = 0;
        rst_n = 0; bp_mode = bp; txen_hi_sel = sel;
        repeat (4) @(negedge clk);
        rst_n = 1; exp_pol = bp && sel;
        @(negedge clk);
        mon_en = 1;
        repeat (5) @(negedge clk);
        chk(txen_out == !exp_pol, "R11 idle enable level", txen_out, !exp_pol);
        chk(pulse1_n == 1'b1, "R1 idle pulse1_n", pulse1_n, 1);
        chk(done == 1'b0, "R1 idle done", done, 0);
        if (!bp) chk(pulse2_n == 1'b1, "R1 idle pulse2_n", pulse2_n, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset(1'b0, 1'b0);
        run_frame(0, 8'h00, 8'h5A, 0, "R4 R2 R3 R9 invite", 0);
        run_frame(1, 8'h00, 8'hC3, 0, "R4 enquiry", 0);
        run_frame(2, 8'h00, 8'h00, 0, "R5 ack", 0);
        run_frame(3, 8'h00, 8'h00, 0, "R5 nak", 0);
        seed = 8'h11;
        run_frame(4, 8'h21, 8'h42, 3, "R6 R8 short data", 0);
        run_frame(4, 8'hFE, 8'h01, 1, "R6 single byte", 0);
        seed = 8'h9C;
        run_frame(4, 8'h07, 8'h80, 255, "R6 R8 longest short", 0);
        run_frame(4, 8'h33, 8'h44, 260, "R7 R8 long data", 0);
        run_frame(4, 8'h55, 8'h66, 20, "R13 busy request", 1);
        repeat (64) @(negedge clk);
        chk(!mon_active && txen_out == !exp_pol, "R13 no extra frame", txen_out, !exp_pol);
        do_reset(1'b0, 1'b1);
        run_frame(2, 8'h00, 8'h00, 0, "R11 high request ignored", 0);
        do_reset(1'b1, 1'b1);
        run_frame(0, 8'h00, 8'hA5, 0, "R10 R11 backplane invite", 0);
        run_frame(4, 8'h12, 8'h34, 5, "R10 backplane data", 0);
        do_reset(1'b1, 1'b0);
        run_frame(3, 8'h00, 8'h00, 0, "R10 R11 backplane low enable", 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule